// File: doc/BRIEF.md
# Deadline Compare Timer

This block is one timer channel paired with its own 64-bit up-counter. The counter advances by one on every clock where the `tick` input is high. Software sets a deadline in one of two ways. It can write the 64-bit absolute compare value as two 32-bit halves. It can also write a signed 32-bit relative value, which the block adds to the present count.

Once enabled, the channel raises a read-only status bit when the count reaches the deadline. It also drives a level interrupt toward an interrupt controller. A mask bit silences the interrupt line but leaves the status bit visible. Software can therefore poll the channel without taking an interrupt.

Registers are reached through a single-cycle interface: writes take effect on the clock edge, and reads are combinational. A read-only register reports the tick rate, so software can convert real time into tick counts.

Top module: `cmp_timer`

## Requirements
- R1: The status bit (control register bit 2) reads 1 exactly when the enable bit is 1 and the counter, taken as unsigned 64-bit, is greater than or equal to the compare value. It is never 1 while the counter is below the compare value.
- R2: The control register sits at offset 0x00. Bit 0 is enable, bit 1 is interrupt mask, and bit 2 is status. Bits 31:3 read as 0. Writing to bit 2 or to bits 31:3 has no effect.
- R3: `irq` is a registered level. One clock after any cycle in which enable=1, status=1 and mask=0, `irq` reads 1; otherwise it reads 0. With mask=1, status still reads 1 while `irq` stays 0.
- R4: Writing 0 to the control register clears status at once. `irq` drops one clock later, whatever the compare value is.
- R5: A write to the relative register (offset 0x10) loads the compare value with the present counter plus the written value, sign-extended to 64 bits.
- R6: A read of the relative register returns bits 31:0 of (compare value minus counter). Taken as signed, this is zero or negative once the deadline has been reached.
- R7: The compare value is read/write as its low half at 0x08 and its high half at 0x0C. Moving it below the counter while enabled raises status. Moving it far beyond the counter clears status.
- R8: Offset 0x14 reads the parameter FREQ_HZ. Writing it has no effect.
- R9: The counter advances by exactly one on each clock with `tick`=1 and holds otherwise. Its low half reads at 0x18 and its high half at 0x1C. Neither offset accepts writes.
- R10: After reset, the control register, the compare value, the counter and `irq` are all 0.
- R11: Offsets outside the map read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Counter advance enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with FREQ_HZ set to 1,000,000 and the default 5-bit offset. Because `tick` is driven by the bench, the counter sits at a known value at every step. Deadlines are swept from several ticks in the past to several ticks in the future, and status, relative readback and `irq` are checked at each counter value, so every side of the greater-or-equal boundary is covered. Extreme relative writes, such as the most negative 32-bit value, reach the sign extension into the compare high half.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  localparam int CNT_W  = 64;
  localparam int DATA_W = 32;

  localparam logic [4:0] OFS_CTL    = 5'h00;
  localparam logic [4:0] OFS_CMP_LO = 5'h08;
  localparam logic [4:0] OFS_CMP_HI = 5'h0C;
  localparam logic [4:0] OFS_REL    = 5'h10;
  localparam logic [4:0] OFS_FREQ   = 5'h14;
  localparam logic [4:0] OFS_CNT_LO = 5'h18;
  localparam logic [4:0] OFS_CNT_HI = 5'h1C;

  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_MASK_BIT = 1;
  localparam int CTL_ST_BIT   = 2;

  // Absolute deadline from a signed relative offset.
  function automatic logic [CNT_W-1:0] rel_to_deadline(
    input logic [CNT_W-1:0]  now,
    input logic [DATA_W-1:0] rel
  );
    logic [CNT_W-1:0] ext;
    ext = {{(CNT_W-DATA_W){rel[DATA_W-1]}}, rel};
    return now + ext;
  endfunction

  // Remaining ticks, truncated to the register width.
  function automatic logic [DATA_W-1:0] deadline_to_rel(
    input logic [CNT_W-1:0] deadline,
    input logic [CNT_W-1:0] now
  );
    logic [CNT_W-1:0] diff;
    diff = deadline - now;
    return diff[DATA_W-1:0];
  endfunction

  function automatic logic deadline_met(
    input logic [CNT_W-1:0] now,
    input logic [CNT_W-1:0] deadline
  );
    return now >= deadline;
  endfunction
endpackage

// File: rtl/cvt_counter.sv
module cvt_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= count + W'(1);
  end
endmodule

// File: rtl/cvt_compare.sv
module cvt_compare
  import cvt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             mask,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] deadline,
  output logic             status,
  output logic             irq_q
);
  logic fire;

  assign status = en && deadline_met(count, deadline);
  assign fire   = status && !mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= fire;
  end
endmodule

// File: rtl/cvt_regs.sv
module cvt_regs
  import cvt_pkg::*;
#(
  parameter int          ADDR_W  = 5,
  parameter logic [31:0] FREQ_HZ = 32'd50_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              status,
  output logic [DATA_W-1:0] rdata,
  output logic              en,
  output logic              mask,
  output logic [CNT_W-1:0]  deadline,
  output logic              rel_wr
);
  localparam int HALF = CNT_W / 2;

  logic hit_ctl, hit_lo, hit_hi, hit_rel, hit_freq, hit_clo, hit_chi;

  assign hit_ctl  = addr == ADDR_W'(OFS_CTL);
  assign hit_lo   = addr == ADDR_W'(OFS_CMP_LO);
  assign hit_hi   = addr == ADDR_W'(OFS_CMP_HI);
  assign hit_rel  = addr == ADDR_W'(OFS_REL);
  assign hit_freq = addr == ADDR_W'(OFS_FREQ);
  assign hit_clo  = addr == ADDR_W'(OFS_CNT_LO);
  assign hit_chi  = addr == ADDR_W'(OFS_CNT_HI);

  assign rel_wr = wr_en && hit_rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      mask     <= 1'b0;
      deadline <= '0;
    end else if (wr_en) begin
      if (hit_ctl) begin
        en   <= wdata[CTL_EN_BIT];
        mask <= wdata[CTL_MASK_BIT];
      end
      if (hit_lo)  deadline[HALF-1:0]     <= wdata;
      if (hit_hi)  deadline[CNT_W-1:HALF] <= wdata;
      if (hit_rel) deadline <= rel_to_deadline(count, wdata);
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_ctl) begin
      rdata[CTL_EN_BIT]   = en;
      rdata[CTL_MASK_BIT] = mask;
      rdata[CTL_ST_BIT]   = status;
    end
    if (hit_lo)   rdata = deadline[HALF-1:0];
    if (hit_hi)   rdata = deadline[CNT_W-1:HALF];
    if (hit_rel)  rdata = deadline_to_rel(deadline, count);
    if (hit_freq) rdata = FREQ_HZ;
    if (hit_clo)  rdata = count[HALF-1:0];
    if (hit_chi)  rdata = count[CNT_W-1:HALF];
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cvt_pkg::*;
#(
  parameter int          ADDR_W  = 5,
  parameter logic [31:0] FREQ_HZ = 32'd50_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cmp_q;
  logic             en_q, mask_q, status, rel_wr;

  cvt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count(cnt_q)
  );

  cvt_regs #(.ADDR_W(ADDR_W), .FREQ_HZ(FREQ_HZ)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .count(cnt_q), .status(status), .rdata(rdata), .en(en_q),
    .mask(mask_q), .deadline(cmp_q), .rel_wr(rel_wr)
  );

  cvt_compare u_cmp (
    .clk(clk), .rst_n(rst_n), .en(en_q), .mask(mask_q), .count(cnt_q),
    .deadline(cmp_q), .status(status), .irq_q(irq)
  );
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic [31:0] wdata,
  input logic [63:0] cnt_q,
  input logic [63:0] cmp_q,
  input logic        en_q,
  input logic        mask_q,
  input logic        rel_wr,
  input logic        irq
);
  a_r9_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt_q == $past(cnt_q) + 64'd1);

  a_r9_counter_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

  a_r3_mask_silences: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |=> !irq);

  a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !irq);

  a_r1_irq_after_deadline: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(cnt_q >= cmp_q));

  a_r5_rel_load: assert property (@(posedge clk) disable iff (!rst_n)
    rel_wr |=> $signed(cmp_q - $past(cnt_q)) == $signed($past(wdata)));
endmodule

bind cmp_timer cmp_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wdata(wdata), .cnt_q(cnt_q),
  .cmp_q(cmp_q), .en_q(en_q), .mask_q(mask_q), .rel_wr(rel_wr), .irq(irq)
);

// File: tb/sim_cmp_timer.sv
`timescale 1ns/1ps
module sim_cmp_timer;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] FREQ       = 32'd1_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [63:0] e_cnt = '0;
  logic [63:0] e_cmp = '0;
  logic        e_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_timer #(.ADDR_W(5), .FREQ_HZ(FREQ)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic step(input logic t);
    tick = t;
    @(negedge clk);
    tick = 1'b0;
    if (t) e_cnt = e_cnt + 64'd1;
  endtask

  function automatic logic e_stat();
    return e_en && (e_cnt >= e_cmp);
  endfunction

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(5'h00, v); chk("R10 ctl", v, 0);
    rd(5'h08, v); chk("R10 cmp_lo", v, 0);
    rd(5'h0C, v); chk("R10 cmp_hi", v, 0);
    rd(5'h18, v); chk("R10 cnt_lo", v, 0);
    chk("R10 irq", irq, 0);

    // R8 frequency, write ignored
    rd(5'h14, v); chk("R8 freq", v, FREQ);
    wr(5'h14, 32'h0);
    rd(5'h14, v); chk("R8 freq after write", v, FREQ);

    // R11 unmapped offset
    rd(5'h04, v); chk("R11 unmapped", v, 0);

    // R9 counter holds without tick, steps with it
    step(0); step(0);
    rd(5'h18, v); chk("R9 hold", v, e_cnt[31:0]);
    for (int i = 0; i < 5; i++) step(1);
    rd(5'h18, v); chk("R9 lo", v, e_cnt[31:0]);
    rd(5'h1C, v); chk("R9 hi", v, e_cnt[63:32]);
    wr(5'h18, 32'hFFFF);
    rd(5'h18, v); chk("R9 ro", v, e_cnt[31:0]);

    // R1 R3 R5 R6 sweep of relative deadlines
    for (int d = -3; d <= 6; d++) begin
      wr(5'h10, 32'(d));
      e_cmp = e_cnt + 64'(signed'(d));
      wr(5'h00, 32'h1);
      e_en = 1'b1;
      rd(5'h08, v); chk("R5 cmp_lo", v, e_cmp[31:0]);
      rd(5'h0C, v); chk("R5 cmp_hi", v, e_cmp[63:32]);
      for (int k = 0; k < 9; k++) begin
        logic [63:0] diff;
        rd(5'h00, v); chk("R1 status", v[2], e_stat());
        diff = e_cmp - e_cnt;
        rd(5'h10, v); chk("R6 rel read", v, diff[31:0]);
        if (e_stat()) chk("R6 non-positive", 64'($signed(v) <= 0), 1);
        step(0);
        chk("R3 irq", irq, e_stat());
        step(1);
      end
    end

    // R3 mask keeps status, silences irq
    wr(5'h00, 32'h3);
    rd(5'h00, v); chk("R3 masked ctl", v, 64'h7);
    step(0);
    chk("R3 masked irq", irq, 0);

    // R4 disable
    wr(5'h00, 32'h1); step(0);
    chk("R4 irq before off", irq, 1);
    wr(5'h00, 32'h0); e_en = 1'b0;
    rd(5'h00, v); chk("R4 ctl off", v, 0);
    step(0);
    chk("R4 irq off", irq, 0);

    // R2 status and upper bits not writable
    wr(5'h00, 32'h4);
    rd(5'h00, v); chk("R2 status ro", v, 0);
    wr(5'h00, 32'hFFFF_FFF9); e_en = 1'b1;
    rd(5'h00, v); chk("R2 upper bits", v, e_stat() ? 64'h5 : 64'h1);

    // R7 move far ahead, then below
    wr(5'h0C, 32'h1); e_cmp[63:32] = 32'h1;
    rd(5'h00, v); chk("R7 far status", v[2], 0);
    step(0); chk("R7 far irq", irq, 0);
    wr(5'h0C, 32'h0); wr(5'h08, 32'h0); e_cmp = '0;
    rd(5'h00, v); chk("R7 below status", v[2], 1);
    step(0); chk("R7 below irq", irq, 1);

    // R5 most negative relative value wraps the high half
    wr(5'h10, 32'h8000_0000);
    e_cmp = e_cnt + 64'hFFFF_FFFF_8000_0000;
    rd(5'h0C, v); chk("R5 sign ext hi", v, e_cmp[63:32]);
    rd(5'h00, v); chk("R5 wrapped status", v[2], e_stat());
    wr(5'h10, 32'h7FFF_FFFF);
    e_cmp = e_cnt + 64'h7FFF_FFFF;
    rd(5'h10, v); chk("R6 max rel", v, 32'h7FFF_FFFF);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule